// File: doc/BRIEF.md
# Reloadable countdown watchdog timer

This block is a system watchdog that software programs through a small byte-addressed register window. A down-counter loses one count on each prescaled tick (one tick stands for 0.6 s, so a period of S seconds is S×10/6 ticks). Software has to keep writing the reload register to refill the counter from a programmable start value. If the count runs out once, a warning flag is raised and the counter refills itself. If it runs out a second time while the warning is still pending, a second flag is set and a reset request leaves the block, unless the no-reboot gate is closed.

A halt bit freezes the counter. The no-reboot gate is a software bit that an external strap can hold closed. The start-value register comes in a wide variant, with a 10-bit field at offset 0x12, and a narrow variant, with a 6-bit field in a byte at offset 0x01. A parameter picks the variant.

Top module: `wdt_core`

## Requirements
- R1: After reset, the halt bit (offset 0x08 bit 11) reads 1 and the no-reboot bit (offset 0x0A bit 0) reads 1. The start value reads 50, which is 30 s × 10 / 6, and the count (offset 0x00) reads 50. Both status registers read 0 and the reset request is low.
- R2: Any write to offset 0x00 loads the counter from the start-value field on the next clock edge. A read of 0x00 returns the current count, zero-extended.
- R3: With halt at 0, every tick lowers a nonzero count by exactly one. With halt at 1, ticks leave the count unchanged.
- R4: A write to the start-value register whose field (bits 9:0 wide, 5:0 narrow) carries a code from 0 to 3 is ignored as a whole, and the register keeps its previous contents.
- R5: An accepted start-value write stores the bits outside the field as written, and the register reads back exactly the last accepted word.
- R6: A tick that arrives while halt is 0 and the count is 0 is an expiry. It refills the counter from the start value and sets the warning flag (offset 0x04 bit 0).
- R7: An expiry while the warning flag is set sets the bark flag (offset 0x06 bit 1). The reset request is high exactly while the bark flag is set and the effective no-reboot bit is 0.
- R8: The effective no-reboot bit is the software bit OR the strap input, and offset 0x0A bit 0 reads back this effective value. While it is 1, the reset request stays low.
- R9: The status flags clear by writing 1 to their bit. Clearing them leaves the count unchanged.
- R10: If a reload write and an expiring tick fall in the same cycle, the reload wins: the counter refills and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaled count enable, one pulse per tick |
| strap_nr_i | input | 1 | Strap that forces the no-reboot gate closed |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Byte address for reads and writes |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| reset_req_o | output | 1 | System reset request |

## Verification
Two functions can fall in the same cycle: a software reload and an expiring tick. The bench counts the counter down to zero, then in one cycle drives a write to offset 0x00 together with a tick. It judges the outcome at the ports: the count must read the full start value, and the warning flag must stay clear. A second overlap is a warning-flag clear against a later expiry. This one is judged through the ordering of the warning and bark flags.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [4:0] OFS_COUNT   = 5'h00;
  localparam logic [4:0] OFS_WARN    = 5'h04;
  localparam logic [4:0] OFS_BARK    = 5'h06;
  localparam logic [4:0] OFS_HALTCTL = 5'h08;
  localparam logic [4:0] OFS_GATE    = 5'h0A;
  localparam logic [4:0] OFS_START_W = 5'h12;
  localparam logic [4:0] OFS_START_N = 5'h01;
  localparam int HALT_POS  = 11;
  localparam int WARN_POS  = 0;
  localparam int BARK_POS  = 1;
  localparam int GATE_POS  = 0;
  localparam int MIN_CODE  = 4;

  // seconds to ticks at 0.6 s per tick
  function automatic int secs_to_ticks(input int secs);
    return (secs * 10) / 6;
  endfunction

  // a start code is usable only from MIN_CODE upward
  function automatic logic start_code_ok(input logic [9:0] code);
    return code >= 10'(MIN_CODE);
  endfunction
endpackage

// File: rtl/wdt_startval.sv
module wdt_startval #(
  parameter int FW  = 10,
  parameter int RW  = 16,
  parameter int DEF = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ev,
  input  logic [RW-1:0] wdata,
  output logic [RW-1:0] reg_q,
  output logic [FW-1:0] field_o,
  output logic          accept_o
);
  import wdt_pkg::*;
  logic [9:0] code_ext;

  assign code_ext = 10'(wdata[FW-1:0]);
  assign accept_o = wr_ev && start_code_ok(code_ext);
  assign field_o  = reg_q[FW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        reg_q <= RW'(DEF);
    else if (accept_o) reg_q <= wdata;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int FW  = 10,
  parameter int DEF = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          halt,
  input  logic          reload,
  input  logic [FW-1:0] load_val,
  output logic [FW-1:0] count,
  output logic          expire
);
  logic run;
  assign run    = tick && !halt;
  assign expire = run && !reload && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= FW'(DEF);
    else if (reload || expire) count <= load_val;
    else if (run)              count <= count - 1'b1;
  end
endmodule

// File: rtl/wdt_status.sv
module wdt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_warn,
  input  logic clr_bark,
  output logic warn,
  output logic bark,
  output logic bark_ev
);
  assign bark_ev = expire && warn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn <= 1'b0;
      bark <= 1'b0;
    end else begin
      warn <= (warn && !clr_warn) || expire;
      bark <= (bark && !clr_bark) || bark_ev;
    end
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter bit WIDE       = 1'b1,
  parameter int DEF_SECS   = 30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        strap_nr_i,
  input  logic        wr_en_i,
  input  logic [4:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        reset_req_o
);
  import wdt_pkg::*;
  localparam int FW  = WIDE ? 10 : 6;
  localparam int RW  = WIDE ? 16 : 8;
  localparam int DEF = secs_to_ticks(DEF_SECS);
  localparam logic [4:0] START_ADDR = WIDE ? OFS_START_W : OFS_START_N;

  logic          halt_q, gate_sw_q, gate_eff;
  logic          reload_ev, start_wr_ev, start_accept, expire_ev, bark_ev;
  logic          clr_warn, clr_bark, warn_q, bark_q;
  logic [RW-1:0] start_q;
  logic [FW-1:0] start_field, count_q;

  assign reload_ev   = wr_en_i && (addr_i == OFS_COUNT);
  assign start_wr_ev = wr_en_i && (addr_i == START_ADDR);
  assign clr_warn    = wr_en_i && (addr_i == OFS_WARN) && wdata_i[WARN_POS];
  assign clr_bark    = wr_en_i && (addr_i == OFS_BARK) && wdata_i[BARK_POS];
  assign gate_eff    = gate_sw_q || strap_nr_i;
  assign reset_req_o = bark_q && !gate_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q    <= 1'b1;
      gate_sw_q <= 1'b1;
    end else if (wr_en_i) begin
      if (addr_i == OFS_HALTCTL) halt_q    <= wdata_i[HALT_POS];
      if (addr_i == OFS_GATE)    gate_sw_q <= wdata_i[GATE_POS];
    end
  end

  wdt_startval #(.FW(FW), .RW(RW), .DEF(DEF)) u_start (
    .clk(clk), .rst_n(rst_n), .wr_ev(start_wr_ev), .wdata(wdata_i[RW-1:0]),
    .reg_q(start_q), .field_o(start_field), .accept_o(start_accept)
  );

  wdt_counter #(.FW(FW), .DEF(DEF)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .halt(halt_q),
    .reload(reload_ev), .load_val(start_field),
    .count(count_q), .expire(expire_ev)
  );

  wdt_status u_sts (
    .clk(clk), .rst_n(rst_n), .expire(expire_ev),
    .clr_warn(clr_warn), .clr_bark(clr_bark),
    .warn(warn_q), .bark(bark_q), .bark_ev(bark_ev)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_COUNT)        rdata_o = 16'(count_q);
    else if (addr_i == START_ADDR)  rdata_o = 16'(start_q);
    else if (addr_i == OFS_WARN)    rdata_o[WARN_POS] = warn_q;
    else if (addr_i == OFS_BARK)    rdata_o[BARK_POS] = bark_q;
    else if (addr_i == OFS_HALTCTL) rdata_o[HALT_POS] = halt_q;
    else if (addr_i == OFS_GATE)    rdata_o[GATE_POS] = gate_eff;
  end
endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk #(
  parameter int FW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_i,
  input logic          strap_nr_i,
  input logic          reset_req_o,
  input logic          halt_q,
  input logic          gate_eff,
  input logic          reload_ev,
  input logic          expire_ev,
  input logic          warn_q,
  input logic          bark_q,
  input logic [FW-1:0] count_q,
  input logic [FW-1:0] start_field
);
  // R3
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !reload_ev) |=> $stable(count_q));
  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !halt_q && !reload_ev && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));
  // R2
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_ev |=> (count_q == $past(start_field)));
  // R4
  start_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_field >= FW'(4));
  // R6
  expire_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_ev |=> (warn_q && count_q == $past(start_field)));
  // R7
  bark_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bark_q) |-> $past(warn_q));
  // R8
  gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> !gate_eff);
  // R8
  strap_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strap_nr_i |-> gate_eff);
  // R10
  reload_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_ev && !warn_q) |=> !warn_q);
endmodule

bind wdt_core wdt_core_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .strap_nr_i(strap_nr_i),
  .reset_req_o(reset_req_o), .halt_q(halt_q), .gate_eff(gate_eff),
  .reload_ev(reload_ev), .expire_ev(expire_ev), .warn_q(warn_q),
  .bark_q(bark_q), .count_q(count_q), .start_field(start_field)
);

// File: tb/wdt_core_test.sv
`timescale 1ns/1ps
module wdt_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        strap_nr_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  addr_i = 5'h00;
  logic [15:0] wdata_i = 16'h0;
  logic [15:0] rdata_o;
  logic        reset_req_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_req;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  wdt_core uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .strap_nr_i(strap_nr_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .reset_req_o(reset_req_o)
  );

  // monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = sb.pop_front();
        act = it.is_req ? 16'(reset_req_o) : rdata_o;
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic rd_exp(input logic [4:0] a, input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk);
    wr_en_i = 1'b0;
    tick_i = 1'b0;
    addr_i = a;
    it.is_req = 1'b0; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic req_exp(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    wr_en_i = 1'b0;
    tick_i = 1'b0;
    it.is_req = 1'b1; it.exp = 16'(e); it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic with_tick);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d; tick_i = with_tick;
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int def_ticks;
    def_ticks = (30 * 10) / 6;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_exp(5'h08, 16'h0800, "R1 halt");
    rd_exp(5'h0A, 16'h0001, "R1 gate");
    rd_exp(5'h12, 16'(def_ticks), "R1 start");
    rd_exp(5'h00, 16'(def_ticks), "R1 count");
    rd_exp(5'h04, 16'h0000, "R1 warn");
    rd_exp(5'h06, 16'h0000, "R1 bark");
    req_exp(1'b0, "R1 reset_req");
    // R3 halted ticks ignored
    ticks(3);
    rd_exp(5'h00, 16'(def_ticks), "R3 halted");
    wr(5'h08, 16'h0000, 1'b0);
    rd_exp(5'h08, 16'h0000, "R3 halt clear");
    ticks(3);
    rd_exp(5'h00, 16'(def_ticks - 3), "R3 decrement");
    // R4 small codes ignored
    wr(5'h12, 16'h0003, 1'b0);
    rd_exp(5'h12, 16'(def_ticks), "R4 code3");
    wr(5'h12, 16'h0000, 1'b0);
    rd_exp(5'h12, 16'(def_ticks), "R4 code0");
    // R5 upper bits kept
    wr(5'h12, 16'hA405, 1'b0);
    rd_exp(5'h12, 16'hA405, "R5 accepted");
    wr(5'h12, 16'hFC02, 1'b0);
    rd_exp(5'h12, 16'hA405, "R4 code2 keeps word");
    // R2 reload
    wr(5'h00, 16'h1234, 1'b0);
    rd_exp(5'h00, 16'd5, "R2 reload");
    ticks(2);
    rd_exp(5'h00, 16'd3, "R3 after reload");
    // R6 first expiry
    ticks(3);
    rd_exp(5'h00, 16'd0, "R6 at zero");
    rd_exp(5'h04, 16'h0000, "R6 no warn yet");
    ticks(1);
    rd_exp(5'h00, 16'd5, "R6 refill");
    rd_exp(5'h04, 16'h0001, "R6 warn");
    req_exp(1'b0, "R6 no reset_req");
    // R9 clear keeps count
    wr(5'h04, 16'h0001, 1'b0);
    rd_exp(5'h04, 16'h0000, "R9 warn clear");
    rd_exp(5'h00, 16'd5, "R9 count kept");
    ticks(6);
    rd_exp(5'h04, 16'h0001, "R6 warn again");
    rd_exp(5'h06, 16'h0000, "R7 no bark yet");
    ticks(6);
    rd_exp(5'h06, 16'h0002, "R7 bark");
    req_exp(1'b0, "R8 gate closed from reset");
    wr(5'h0A, 16'h0000, 1'b0);
    rd_exp(5'h0A, 16'h0000, "R8 gate open");
    req_exp(1'b1, "R7 reset_req");
    @(negedge clk); strap_nr_i = 1'b1;
    rd_exp(5'h0A, 16'h0001, "R8 strap readback");
    req_exp(1'b0, "R8 strap blocks");
    @(negedge clk); strap_nr_i = 1'b0;
    req_exp(1'b1, "R7 strap released");
    rd_exp(5'h00, 16'd5, "R7 count");
    wr(5'h06, 16'h0002, 1'b0);
    rd_exp(5'h06, 16'h0000, "R9 bark clear");
    req_exp(1'b0, "R9 reset_req drops");
    rd_exp(5'h00, 16'd5, "R9 count kept bark");
    // R10 reload vs expiring tick
    wr(5'h04, 16'h0001, 1'b0);
    ticks(5);
    rd_exp(5'h00, 16'd0, "R10 at zero");
    wr(5'h00, 16'h0000, 1'b1);
    rd_exp(5'h00, 16'd5, "R10 refilled");
    rd_exp(5'h04, 16'h0000, "R10 no warn");
    // R3 halt again
    wr(5'h08, 16'h0800, 1'b0);
    ticks(2);
    rd_exp(5'h00, 16'd5, "R3 halted again");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule